// File: doc/BRIEF.md
# Push-Button Debouncer with Twin Level Counters

This block cleans up the signal from one mechanical push-button. The contacts chatter when the key is pressed and when it is released, so the raw line can toggle many times before it settles. The block first passes the raw line through a two-flop synchronizer. It then samples the line on a slow tick that comes from a clock divider inside the block. It commits a new clean level only after the sampled line has held that level, without a break, for a programmed number of ticks. With the default settings the divider turns a 100 MHz clock into a 25 MHz tick, and the terminal count of 1,250,000 ticks gives a hold time of about 50 ms.

The key is active low, so a pressed key reads as 0. Two counters do the qualifying. One counts ticks while the sampled line is high, and the other counts ticks while it is low. Each counter clears whenever the line is at the opposite level. When a counter reaches terminal count it wraps to zero and asks for the clean output to go to its own level. When a request actually changes the clean output, the block raises a one-cycle change pulse.

The clean level drives any logic that must see a single press per actuation. The change pulse suits edge-triggered consumers such as event counters.

Top module: `keydeb_top`

## Requirements
- R1: While the synchronous reset is high, and in the first cycle after it is released, `key_clean_n` is 1 (released) and `key_change` is 0.
- R2: Suppose the raw input is held at 0 (pressed) without a break for at least `TERM*DIV + DIV + 4` clock cycles. Then `key_clean_n` is 0 by the end of that hold.
- R3: Suppose the raw input is held at 1 (released) without a break for at least `TERM*DIV + DIV + 4` clock cycles. Then `key_clean_n` is 1 by the end of that hold.
- R4: A run of either level that lasts `(TERM-1)*DIV` clock cycles or fewer leaves `key_clean_n` and `key_change` unchanged.
- R5: `key_change` is high for exactly one cycle, in the same cycle in which `key_clean_n` takes its new value. It never rises when the level does not change, including when the counter of the level already shown wraps again.
- R6: Sampling advances only once every `DIV` clock cycles. A clean-level change therefore needs `TERM` ticks in which the synchronized input is unbroken at the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_raw_n | input | 1 | Raw button line, 0 = pressed, asynchronous |
| key_clean_n | output | 1 | Debounced level, 0 = pressed, 1 after reset |
| key_change | output | 1 | One-cycle pulse on each committed change of `key_clean_n` |

## Verification
The counter of the level already on the output keeps running and wraps every `TERM` ticks. Its terminal count can therefore land in the same cycle as, or just before, a real change driven by the opposite counter. The bench provokes this with long holds of random length, many times longer than the terminal count, that alternate with random chatter bursts. It judges the result by comparing the number of change pulses, and the clean level, against a model that counts only real level changes. Directed runs at exactly the bounce limit and at the shortest qualifying hold pin down the boundary between R4 and R2/R3.

// File: rtl/keydeb_pkg.sv
package keydeb_pkg;

    localparam int unsigned DEF_DIV  = 4;
    localparam int unsigned DEF_TERM = 1250000;

    // Index of each level counter in the request vector
    localparam int unsigned IDX_LOW  = 0;
    localparam int unsigned IDX_HIGH = 1;
    localparam int unsigned NUM_LVL  = 2;

    // Width needed to count 0 .. n-1 (at least one bit)
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Clean output state carried as one record
    typedef struct packed {
        logic level;
        logic change;
    } key_state_t;

    localparam key_state_t KEY_RESET = '{level: 1'b1, change: 1'b0};

endpackage

// File: rtl/keydeb_sync.sv
module keydeb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/keydeb_tick.sv
module keydeb_tick #(
    parameter int unsigned DIV = keydeb_pkg::DEF_DIV
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned DW = keydeb_pkg::cnt_width(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = (div_q == LAST);
endmodule

// File: rtl/keydeb_runcnt.sv
module keydeb_runcnt #(
    parameter bit          LEVEL = 1'b0,
    parameter int unsigned TERM  = keydeb_pkg::DEF_TERM
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic smp,
    output logic hit
);
    localparam int unsigned CW = keydeb_pkg::cnt_width(TERM);
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    logic [CW-1:0] run_q;
    logic          at_level;

    assign at_level = (smp == LEVEL);
    assign hit      = at_level && tick && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !at_level) begin
            run_q <= '0;
        end else if (tick) begin
            if (run_q == LAST) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/keydeb_top.sv
module keydeb_top
    import keydeb_pkg::*;
#(
    parameter int unsigned DIV  = DEF_DIV,
    parameter int unsigned TERM = DEF_TERM
) (
    input  logic clk,
    input  logic rst,
    input  logic key_raw_n,
    output logic key_clean_n,
    output logic key_change
);
    logic               smp_lvl;
    logic               smp_tick;
    logic [NUM_LVL-1:0] lvl_hit;
    key_state_t         st_q;

    keydeb_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (key_raw_n),
        .dout (smp_lvl)
    );

    keydeb_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (smp_tick)
    );

    for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_run
        keydeb_runcnt #(
            .LEVEL (1'(gi)),
            .TERM  (TERM)
        ) u_run (
            .clk  (clk),
            .rst  (rst),
            .tick (smp_tick),
            .smp  (smp_lvl),
            .hit  (lvl_hit[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= KEY_RESET;
        end else begin
            st_q.change <= 1'b0;
            if (lvl_hit[IDX_HIGH] && !st_q.level) begin
                st_q.level  <= 1'b1;
                st_q.change <= 1'b1;
            end else if (lvl_hit[IDX_LOW] && st_q.level) begin
                st_q.level  <= 1'b0;
                st_q.change <= 1'b1;
            end
        end
    end

    assign key_clean_n = st_q.level;
    assign key_change  = st_q.change;
endmodule

// File: rtl/keydeb_chk.sv
module keydeb_chk #(
    parameter int unsigned DIV  = 4,
    parameter int unsigned TERM = 8
) (
    input logic clk,
    input logic rst,
    input logic smp,
    input logic tick,
    input logic key_clean_n,
    input logic key_change
);
    localparam int unsigned RW = $clog2(TERM + 1);
    localparam logic [RW-1:0] SAT = RW'(TERM);

    logic [RW-1:0] lo_run;
    logic [RW-1:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst || smp) lo_run <= '0;
        else if (tick && lo_run != SAT) lo_run <= lo_run + 1'b1;
        if (rst || !smp) hi_run <= '0;
        else if (tick && hi_run != SAT) hi_run <= hi_run + 1'b1;
    end

    // R1
    rst_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (key_clean_n && !key_change));

    // R2 R4 R6
    fall_run_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(key_clean_n) |-> ($past(lo_run) >= RW'(TERM - 1) && $past(tick) && !$past(smp)));

    // R3 R4 R6
    rise_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(key_clean_n) |-> ($past(hi_run) >= RW'(TERM - 1) && $past(tick) && $past(smp)));

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        key_change |=> !key_change);

    // R5
    pulse_on_change_chk: assert property (@(posedge clk) disable iff (rst)
        (key_clean_n != $past(key_clean_n)) |-> key_change);

    // R5
    change_has_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        key_change |-> (key_clean_n != $past(key_clean_n)));

    // R6
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

bind keydeb_top keydeb_chk #(.DIV(DIV), .TERM(TERM)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp         (smp_lvl),
    .tick        (smp_tick),
    .key_clean_n (key_clean_n),
    .key_change  (key_change)
);

// File: tb/keydeb_top_tb.sv
module keydeb_top_tb;
    localparam int unsigned DIV   = 4;
    localparam int unsigned TERM  = 8;
    localparam int unsigned LONG  = TERM * DIV + DIV + 4;
    localparam int unsigned SHORT = (TERM - 1) * DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_raw_n = 1'b1;
    logic key_clean_n;
    logic key_change;

    int n_checks = 0;
    int n_fail   = 0;
    int seen_pulses = 0;
    int exp_pulses  = 0;
    logic exp_level = 1'b1;
    logic prev_chg  = 1'b0;
    logic done      = 1'b0;
    int unsigned seed_sink;

    always #10 clk = ~clk;

    keydeb_top #(.DIV(DIV), .TERM(TERM)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .key_raw_n   (key_raw_n),
        .key_clean_n (key_clean_n),
        .key_change  (key_change)
    );

    // Pulse monitor; a pulse two cycles wide breaks R5
    always @(negedge clk) begin
        if (!rst) begin
            if (key_change) seen_pulses++;
            if (key_change && prev_chg) begin
                n_checks++;
                n_fail++;
                $display("FAIL R5: change pulse wider than one cycle, actual 2 expected 1");
            end
            prev_chg = key_change;
        end else begin
            prev_chg = 1'b0;
        end
    end

    function automatic logic next_level(input logic cur, input logic lvl, input bit is_long);
        return is_long ? lvl : cur;
    endfunction

    function automatic int next_pulses(input int cur, input logic old_lvl, input logic new_lvl);
        return (old_lvl != new_lvl) ? cur + 1 : cur;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Hold one level for len cycles, then compare against the model
    task automatic hold(input logic lvl, input int unsigned len, input string tag);
        bit   is_long;
        logic nl;
        is_long = (len >= LONG);
        key_raw_n = lvl;
        repeat (len) @(negedge clk);
        nl = next_level(exp_level, lvl, is_long);
        exp_pulses = next_pulses(exp_pulses, exp_level, nl);
        exp_level = nl;
        check(key_clean_n == exp_level, {tag, " level"}, int'(key_clean_n), int'(exp_level));
        check(seen_pulses == exp_pulses, {tag, " pulses"}, seen_pulses, exp_pulses);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic lvl;
        seed_sink = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(key_clean_n == 1'b1, "R1 level in reset", int'(key_clean_n), 1);
        check(key_change == 1'b0, "R1 pulse in reset", int'(key_change), 0);
        rst = 1'b0;
        @(negedge clk);
        check(key_clean_n == 1'b1 && key_change == 1'b0, "R1 after release", int'(key_clean_n), 1);

        // Directed: bounce at exact limit, then shortest qualifying hold (R4 R6 R2 R3)
        hold(1'b0, SHORT, "R4 R6 press burst at limit");
        hold(1'b1, 3, "R4 gap");
        hold(1'b0, LONG, "R2 shortest press");
        hold(1'b1, SHORT, "R4 R6 release burst at limit");
        hold(1'b0, 2, "R4 gap");
        hold(1'b1, LONG, "R3 shortest release");

        // Random chatter mixed with long holds; long holds let the held counter wrap (R5)
        lvl = 1'b0;
        for (int i = 0; i < 120; i++) begin
            if ($urandom_range(0, 2) == 0) begin
                hold(lvl, LONG + $urandom_range(0, 3 * TERM * DIV),
                     lvl ? "R3 R5 random release" : "R2 R5 random press");
            end else begin
                hold(lvl, $urandom_range(1, SHORT), "R4 random chatter");
            end
            lvl = ~lvl;
        end

        // Reset while pressed returns to released (R1), then press again (R2)
        key_raw_n = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(key_clean_n == 1'b1 && key_change == 1'b0, "R1 reset while pressed", int'(key_clean_n), 1);
        rst = 1'b0;
        exp_level = 1'b1;
        seen_pulses = 0;
        exp_pulses = 0;
        hold(1'b0, LONG, "R2 press after reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule